// File: doc/BRIEF.md
# Secured Configuration Store Controller

This block owns the non-volatile image of a small programmable logic device: the product-term connection words, a global mode field, per-cell polarity and register-select bits, a 64-bit identification word, and a one-way lock bit. A programmer issues single commands through a valid/opcode/address/data port. Each accepted command keeps `busy_o` high for a fixed number of cycles and then completes with a one-cycle `done_o` pulse. Read results and a refusal flag arrive together with that pulse.

Erasing clears the whole image, the identification word and the lock at the same time. Programming can only close connections, which are stored as 1 bits. The only way to reopen a connection is to erase the whole store. Once the lock is set, it refuses readback and programming until the next erase. The decoded image is driven out continuously so the logic array can use it.

Top module: `cfg_store_ctrl`

## Requirements
- R1: After reset, every stored bit is 0, `secure_o` is 0, and `busy_o`, `done_o` and `err_o` are all 0.
- R2: A command is taken when `cmd_valid_i` is high and `busy_o` is low. It holds `busy_o` high for BUSY_CYC cycles (default 3), and `done_o` then pulses for one cycle. Commands presented while busy are ignored. Opcodes: 0 none, 1 erase, 2 program, 3 verify, 4 lock, 5 id write, 6 id read, 7 program-then-lock.
- R3: Erase sets every connection word, architecture word and id lane to 0 and clears the lock. It is never refused.
- R4: Program ORs the data into the addressed word, so bits already at 1 stay at 1.
- R5: Verify returns the addressed word on `rdata_o` in the `done_o` cycle. Addresses 0..N_WORDS-1 (default 15) hold connection words. N_WORDS holds the mode word (bits 1:0). N_WORDS+1 holds per-cell polarity and N_WORDS+2 holds per-cell register select, with bit i belonging to cell i.
- R6: The lock opcode sets `secure_o`. Program-then-lock writes the word and sets `secure_o` in the same completion.
- R7: While locked, verify, program, program-then-lock, id write and id read are refused. A refused command pulses `err_o` with `done_o`, returns 0 on `rdata_o`, and changes no stored bit.
- R8: Id write replaces the 8-bit lane selected by address 0..7, with lane i at bits 8i+7:8i. Id read returns that lane.
- R9: A word address at or above N_WORDS+3, or an id lane address at or above 8, is refused as in R7, even when unlocked.
- R10: `conn_o` word i (bits 8i+7:8i), `mode_o`, `cell_pol_o` and `cell_reg_o` always show the stored image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 3 | Opcode |
| cmd_addr_i | input | 5 | Word address or id lane |
| cmd_data_i | input | 8 | Write data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Command refused, valid with done_o |
| rdata_o | output | 8 | Read result, valid with done_o |
| secure_o | output | 1 | Lock state |
| conn_o | output | 128 | Connection words, flattened |
| mode_o | output | 2 | Global mode field |
| cell_pol_o | output | 8 | Per-cell polarity bits |
| cell_reg_o | output | 8 | Per-cell register select bits |

## Verification
Assertions run on every cycle and check the following:
- Connections never reopen except when a completed erase clears everything.
- The image is frozen while the lock is held.
- The lock only drops at a clean erase completion.
- Refusals carry zero data.
- `done_o` is a single pulse that follows a busy period.

The bench scenarios are needed for the rest. Only they show the exact busy length, that a command offered mid-operation is dropped, the address decoding of the architecture words and id lanes, and the set of opcodes refused under the lock.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_ERASE     = 3'd1,
    OP_PROG      = 3'd2,
    OP_VERIFY    = 3'd3,
    OP_SECURE    = 3'd4,
    OP_SIG_WR    = 3'd5,
    OP_SIG_RD    = 3'd6,
    OP_PROG_LOCK = 3'd7
  } cfg_op_e;
endpackage

// File: rtl/cfg_cmd_seq.sv
module cfg_cmd_seq #(
  parameter int BUSY_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic accept_o,
  output logic fire_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  assign accept_o = valid_i & ~busy_q;
  assign fire_o   = busy_q & (cnt_q == '0);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fire_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(BUSY_CYC - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_access_guard.sv
module cfg_access_guard
  import cfg_store_pkg::*;
#(
  parameter int TOT_WORDS = 19,
  parameter int SIG_LANES = 8,
  parameter int ADDR_W    = 5
) (
  input  cfg_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              secure_i,
  output logic              refuse_o
);
  logic word_ok, lane_ok;

  assign word_ok = 32'(addr_i) < TOT_WORDS;
  assign lane_ok = 32'(addr_i) < SIG_LANES;

  always_comb begin
    unique case (op_i)
      OP_PROG, OP_PROG_LOCK, OP_VERIFY: refuse_o = secure_i | ~word_ok;
      OP_SIG_WR, OP_SIG_RD:             refuse_o = secure_i | ~lane_ok;
      default:                          refuse_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_store_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int N_WORDS   = 16,
  parameter int N_CELLS   = 8,
  parameter int SIG_W     = 64,
  parameter int ADDR_W    = 5,
  localparam int TOT_WORDS = N_WORDS + 3,
  localparam int SIG_LANES = SIG_W / WORD_W,
  localparam int SIG_AW    = $clog2(SIG_LANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fire_i,
  input  logic                      refuse_i,
  input  cfg_op_e                   op_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [WORD_W-1:0]         data_i,
  output logic [WORD_W-1:0]         rdata_o,
  output logic                      err_o,
  output logic                      secure_o,
  output logic [N_WORDS*WORD_W-1:0] conn_o,
  output logic [1:0]                mode_o,
  output logic [N_CELLS-1:0]        cell_pol_o,
  output logic [N_CELLS-1:0]        cell_reg_o
);
  logic [WORD_W-1:0] mem_q [TOT_WORDS];
  logic [WORD_W-1:0] sig_q [SIG_LANES];
  logic [WORD_W-1:0] rdata_q;
  logic              sec_q, err_q;
  logic [SIG_AW-1:0] lane;

  assign lane = addr_i[SIG_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TOT_WORDS; i++) mem_q[i] <= '0;
      for (int i = 0; i < SIG_LANES; i++) sig_q[i] <= '0;
      sec_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      err_q <= 1'b0;
      if (fire_i) begin
        err_q   <= refuse_i;
        rdata_q <= '0;
        if (!refuse_i) begin
          unique case (op_i)
            OP_ERASE: begin
              for (int i = 0; i < TOT_WORDS; i++) mem_q[i] <= '0;
              for (int i = 0; i < SIG_LANES; i++) sig_q[i] <= '0;
              sec_q <= 1'b0;
            end
            OP_PROG:      mem_q[addr_i] <= mem_q[addr_i] | data_i;
            OP_PROG_LOCK: begin
              mem_q[addr_i] <= mem_q[addr_i] | data_i;
              sec_q         <= 1'b1;
            end
            OP_VERIFY:    rdata_q     <= mem_q[addr_i];
            OP_SECURE:    sec_q       <= 1'b1;
            OP_SIG_WR:    sig_q[lane] <= data_i;
            OP_SIG_RD:    rdata_q     <= sig_q[lane];
            default: ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_conn
    assign conn_o[g*WORD_W +: WORD_W] = mem_q[g];
  end

  assign mode_o     = mem_q[N_WORDS][1:0];
  assign cell_pol_o = mem_q[N_WORDS+1][N_CELLS-1:0];
  assign cell_reg_o = mem_q[N_WORDS+2][N_CELLS-1:0];
  assign rdata_o    = rdata_q;
  assign err_o      = err_q;
  assign secure_o   = sec_q;
endmodule

// File: rtl/cfg_store_ctrl.sv
module cfg_store_ctrl
  import cfg_store_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int N_WORDS  = 16,
  parameter int N_CELLS  = 8,
  parameter int SIG_W    = 64,
  parameter int BUSY_CYC = 3,
  localparam int ADDR_W  = $clog2(N_WORDS + 3 + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_valid_i,
  input  logic [2:0]                cmd_op_i,
  input  logic [ADDR_W-1:0]         cmd_addr_i,
  input  logic [WORD_W-1:0]         cmd_data_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o,
  output logic [WORD_W-1:0]         rdata_o,
  output logic                      secure_o,
  output logic [N_WORDS*WORD_W-1:0] conn_o,
  output logic [1:0]                mode_o,
  output logic [N_CELLS-1:0]        cell_pol_o,
  output logic [N_CELLS-1:0]        cell_reg_o
);
  logic              accept, fire, refuse;
  cfg_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NOP;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= cfg_op_e'(cmd_op_i);
      addr_q <= cmd_addr_i;
      data_q <= cmd_data_i;
    end
  end

  cfg_cmd_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
    .clk_i, .rst_ni,
    .valid_i  (cmd_valid_i),
    .accept_o (accept),
    .fire_o   (fire),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  cfg_access_guard #(
    .TOT_WORDS(N_WORDS + 3), .SIG_LANES(SIG_W / WORD_W), .ADDR_W(ADDR_W)
  ) u_guard (
    .op_i     (op_q),
    .addr_i   (addr_q),
    .secure_i (secure_o),
    .refuse_o (refuse)
  );

  cfg_store #(
    .WORD_W(WORD_W), .N_WORDS(N_WORDS), .N_CELLS(N_CELLS),
    .SIG_W(SIG_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk_i, .rst_ni,
    .fire_i     (fire),
    .refuse_i   (refuse),
    .op_i       (op_q),
    .addr_i     (addr_q),
    .data_i     (data_q),
    .rdata_o    (rdata_o),
    .err_o      (err_o),
    .secure_o   (secure_o),
    .conn_o     (conn_o),
    .mode_o     (mode_o),
    .cell_pol_o (cell_pol_o),
    .cell_reg_o (cell_reg_o)
  );
endmodule

// File: rtl/cfg_store_ctrl_chk.sv
module cfg_store_ctrl_chk #(
  parameter int WORD_W  = 8,
  parameter int CONN_W  = 128,
  parameter int N_CELLS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [WORD_W-1:0] rdata_o,
  input logic              secure_o,
  input logic [CONN_W-1:0] conn_o,
  input logic [1:0]        mode_o,
  input logic [N_CELLS-1:0] cell_pol_o,
  input logic [N_CELLS-1:0] cell_reg_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o)); // R2
  AST_BUSY_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cmd_valid_i)); // R2
  AST_SEC_CLEAR_ON_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(secure_o) |-> (done_o && !err_o && conn_o == '0)); // R3
  AST_NO_REOPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(conn_o) & ~conn_o) != '0) |-> (done_o && conn_o == '0)); // R4
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secure_o && $past(secure_o)) |->
      ($stable(conn_o) && $stable(mode_o) && $stable(cell_pol_o) && $stable(cell_reg_o))); // R7
  AST_REFUSE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && rdata_o == '0)); // R7
endmodule

bind cfg_store_ctrl cfg_store_ctrl_chk #(
  .WORD_W(WORD_W), .CONN_W(N_WORDS*WORD_W), .N_CELLS(N_CELLS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
  .secure_o(secure_o), .conn_o(conn_o), .mode_o(mode_o),
  .cell_pol_o(cell_pol_o), .cell_reg_o(cell_reg_o)
);

// File: tb/sim_cfg_store_ctrl.sv
module sim_cfg_store_ctrl;
  localparam int WORD_W = 8, N_WORDS = 16, N_CELLS = 8, SIG_W = 64, BUSY_CYC = 3;
  localparam int TOT = N_WORDS + 3, LANES = SIG_W / WORD_W, AW = 5;
  localparam logic [2:0] C_NOP = 0, C_ERASE = 1, C_PROG = 2, C_VER = 3,
                         C_LOCK = 4, C_SWR = 5, C_SRD = 6, C_PLOCK = 7;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [WORD_W-1:0] cmd_data = 0;
  logic busy, done, err, secure;
  logic [WORD_W-1:0] rdata;
  logic [N_WORDS*WORD_W-1:0] conn;
  logic [1:0] mode;
  logic [N_CELLS-1:0] pol, regsel;

  always #10 clk = ~clk;

  cfg_store_ctrl #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .N_CELLS(N_CELLS),
                   .SIG_W(SIG_W), .BUSY_CYC(BUSY_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_data_i(cmd_data), .busy_o(busy), .done_o(done),
    .err_o(err), .rdata_o(rdata), .secure_o(secure), .conn_o(conn),
    .mode_o(mode), .cell_pol_o(pol), .cell_reg_o(regsel));

  int n_cmp = 0, n_bad = 0;
  logic [WORD_W-1:0] m_mem [TOT];
  logic [WORD_W-1:0] m_sig [LANES];
  logic [WORD_W-1:0] r_data;
  logic r_err;
  int r_busy;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wait_done();
    int guard = 0;
    r_busy = 0;
    while (!done && guard < 50) begin
      if (busy) r_busy++;
      @(negedge clk);
      guard++;
    end
    r_data = rdata;
    r_err  = err;
  endtask

  task automatic issue(input logic [2:0] op, input int addr, input logic [WORD_W-1:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(addr); cmd_data = d;
    @(negedge clk);
    cmd_valid = 0;
    wait_done();
    chk("R2 busy length", 128'(r_busy), 128'(BUSY_CYC));
  endtask

  task automatic check_image(input string req);
    logic [N_WORDS*WORD_W-1:0] e;
    for (int i = 0; i < N_WORDS; i++) e[i*WORD_W +: WORD_W] = m_mem[i];
    chk(req, 128'(conn), 128'(e));
    chk(req, 128'(mode), 128'(m_mem[N_WORDS][1:0]));
    chk(req, 128'(pol), 128'(m_mem[N_WORDS+1]));
    chk(req, 128'(regsel), 128'(m_mem[N_WORDS+2]));
  endtask

  task automatic verify_all(input string req);
    for (int a = 0; a < TOT; a++) begin
      issue(C_VER, a, 0);
      chk(req, 128'({r_err, r_data}), 128'({1'b0, m_mem[a]}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < TOT; i++) m_mem[i] = '0;
    for (int i = 0; i < LANES; i++) m_sig[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags", 128'({busy, done, err, secure}), 128'(0));
    chk("R1 image", 128'({conn, mode, pol, regsel}), 128'(0));
    rst_n = 1;
    @(negedge clk);

    issue(C_NOP, 0, 0);
    chk("R2 nop no error", 128'(r_err), 128'(0));

    // R2 command offered while busy is dropped
    @(negedge clk);
    cmd_valid = 1; cmd_op = C_PROG; cmd_addr = 0; cmd_data = 8'h0F;
    @(negedge clk);
    chk("R2 busy after accept", 128'(busy), 128'(1));
    cmd_op = C_ERASE;
    @(negedge clk);
    cmd_valid = 0;
    wait_done();
    m_mem[0] = 8'h0F;
    begin
      int stray = 0;
      @(negedge clk);
      chk("R2 done single", 128'(done), 128'(0));
      repeat (6) begin @(negedge clk); if (done) stray++; end
      chk("R2 no second command", 128'(stray), 128'(0));
    end
    issue(C_VER, 0, 0);
    chk("R2 erase while busy ignored", 128'(r_data), 128'(8'h0F));

    // R4 R5 program sweep, twice to exercise OR accumulation
    for (int a = 0; a < TOT; a++) begin
      logic [WORD_W-1:0] p = 8'(a * 37 + 5);
      issue(C_PROG, a, p);
      m_mem[a] |= p;
    end
    verify_all("R5 verify first pass");
    for (int a = 0; a < TOT; a++) begin
      logic [WORD_W-1:0] p = 8'(a * 91 + 48);
      issue(C_PROG, a, p);
      m_mem[a] |= p;
    end
    issue(C_PROG, 3, 8'h00);
    verify_all("R4 closures accumulate");
    check_image("R10 image outputs");

    // R9 out of range
    for (int a = TOT; a < 32; a++) begin
      issue(C_VER, a, 0);
      chk("R9 verify out of range", 128'({r_err, r_data}), 128'({1'b1, 8'h00}));
    end
    issue(C_PROG, 25, 8'hFF);
    chk("R9 program out of range", 128'(r_err), 128'(1));
    check_image("R9 image unchanged");
    issue(C_SWR, 9, 8'h55);
    chk("R9 id lane out of range", 128'(r_err), 128'(1));

    // R8 id word
    for (int l = 0; l < LANES; l++) begin
      issue(C_SWR, l, 8'(l * 29 + 1));
      m_sig[l] = 8'(l * 29 + 1);
    end
    issue(C_SWR, 3, 8'h00);
    m_sig[3] = 8'h00;
    for (int l = 0; l < LANES; l++) begin
      issue(C_SRD, l, 0);
      chk("R8 id readback", 128'({r_err, r_data}), 128'({1'b0, m_sig[l]}));
    end

    // R6 R7 lock
    issue(C_LOCK, 0, 0);
    chk("R6 lock set", 128'({r_err, secure}), 128'({1'b0, 1'b1}));
    issue(C_VER, 1, 0);
    chk("R7 verify refused", 128'({r_err, r_data}), 128'({1'b1, 8'h00}));
    issue(C_PROG, 1, 8'hFF);
    chk("R7 program refused", 128'(r_err), 128'(1));
    issue(C_PLOCK, 2, 8'hFF);
    chk("R7 program-lock refused", 128'(r_err), 128'(1));
    issue(C_SRD, 1, 0);
    chk("R7 id read refused", 128'({r_err, r_data}), 128'({1'b1, 8'h00}));
    issue(C_SWR, 1, 8'hEE);
    chk("R7 id write refused", 128'(r_err), 128'(1));
    check_image("R7 image frozen");

    // R3 erase
    issue(C_ERASE, 0, 0);
    for (int i = 0; i < TOT; i++) m_mem[i] = '0;
    for (int i = 0; i < LANES; i++) m_sig[i] = '0;
    chk("R3 erase clears lock", 128'({r_err, secure}), 128'(0));
    check_image("R3 image cleared");
    verify_all("R3 words open");
    issue(C_SRD, 1, 0);
    chk("R3 id cleared", 128'({r_err, r_data}), 128'(0));

    // R6 program then lock
    issue(C_PLOCK, 5, 8'hA5);
    m_mem[5] = 8'hA5;
    chk("R6 program-lock locks", 128'({r_err, secure}), 128'({1'b0, 1'b1}));
    check_image("R6 program-lock wrote");
    issue(C_ERASE, 0, 0);
    m_mem[5] = '0;
    chk("R3 second erase", 128'({secure, conn}), 128'(0));

    finish_run();
  end
endmodule